// File: doc/BRIEF.md
# RAM Block Base Mapper

This block maps a memory-capable plug-in virtual module that holds up to eight 128 KB RAM blocks into a 1 MB, 20-bit memory space. Each block has its own control byte. A set enable bit turns the block on, and a 3-bit field places the block's lower boundary at a multiple of 128 KB. Host software writes these control bytes through the module's local I/O window. At the start of every memory bus cycle, the mapper compares the three top address bits with the base of every enabled block. It then selects one block and gives that block byte-lane read and write enables for the rest of the cycle.

Blocks must be fitted contiguously from block 0. The parameter `POP_BLOCKS` gives how many are fitted. Control bytes above that count cannot be written, read back as zero and never select. Reset clears every control byte, and clearing the low bytes does the same, so the module answers no memory access until software enables a block. If two enabled blocks claim the same base, the lower-numbered one wins.

The cycle tracker is a three-state machine:
- `ST_IDLE` means no memory cycle is in progress.
- `ST_HIT` means a latched memory cycle matched a block.
- `ST_MISS` means a latched memory cycle matched nothing.

Its transitions are:
- latch-hit: `bus_ale` with `bus_mem`, and a match, goes to `ST_HIT`.
- latch-miss: `bus_ale` with `bus_mem`, and no match, goes to `ST_MISS`.
- latch-io: `bus_ale` without `bus_mem` goes to `ST_IDLE`.
- done: `bus_done` without `bus_ale` goes to `ST_IDLE`.
- hold: with neither strobe, the state stays where it is.

Top module: `ram_block_mapper`

## Requirements
- R1: A write of the local I/O window updates control byte n at the clock edge. The write needs `io_sel`, `io_wr`, `io_addr[0]`=0 and `io_addr[3:1]`=n. The byte is taken whole from `io_wdata`. Bit 7 is the enable and bits 3..1 are the base in units of 128 KB.
- R2: While `io_sel` is high, `io_rdata[7:0]` shows control byte `io_addr[3:1]`. `io_rdata[15:8]` shows `ID_CODE` for word 0 and 0 for every other word. While `io_sel` is low, `io_rdata` is 0.
- R3: Control bytes with index at or above `POP_BLOCKS` ignore writes, read back 0 and never select a block.
- R4: Reset clears every control byte and puts the tracker in `ST_IDLE`. While no enable bit is set, no memory cycle asserts any select or lane enable.
- R5: A memory cycle is latched when `bus_ale` and `bus_mem` are high. From the next cycle, `blk_sel[n]` is high when block n is enabled and its base equals `bus_base` (address bits 19..17).
- R6: When several enabled blocks match, only the lowest-numbered one is selected, so `blk_sel` is one-hot or zero.
- R7: Lanes are latched with the address. Bit 0 (low byte) is set when `bus_a0`=0, and bit 1 (high byte) is set when `bus_hbe_n`=0. During a hit, `lane_we` equals the lanes while `bus_wr` is high, and `lane_re` equals the lanes while `bus_rd` is high. Both are 0 otherwise.
- R8: An I/O cycle (`bus_ale` with `bus_mem`=0) and a miss give no select. `bus_done` clears selects and enables from the next cycle. `bus_ale` takes priority over `bus_done`.
- R9: Writes to odd local addresses (high bytes) change nothing. The identification byte stays read-only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| io_sel | input | 1 | Local I/O window selected |
| io_wr | input | 1 | Local I/O write strobe |
| io_addr | input | 4 | Byte address in the window; bits 3..1 give the word, bit 0 the byte |
| io_wdata | input | 8 | Low-byte write data |
| io_rdata | output | 16 | Readback word |
| bus_ale | input | 1 | Start of a bus cycle; latches the address |
| bus_mem | input | 1 | 1 for memory space, 0 for I/O space |
| bus_base | input | 3 | Address bits 19..17 |
| bus_a0 | input | 1 | Address bit 0 |
| bus_hbe_n | input | 1 | Active-low high-byte enable |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_done | input | 1 | End of a bus cycle |
| blk_sel | output | 8 | One-hot block select |
| lane_we | output | 2 | Lane write enables (bit 0 low byte, bit 1 high byte) |
| lane_re | output | 2 | Lane read enables (bit 0 low byte, bit 1 high byte) |

## Verification
A corrupted control byte shows up in two places at once. It appears on `io_rdata` in the same cycle the word is addressed. It also appears as a wrong or missing `blk_sel` in the cycle after the next address latch. A tracker stuck in the wrong state shows as selects that persist after `bus_done` or after an I/O cycle, or as lane enables with no select, one cycle after the strobe. The bench compares every output against a behavioural model on every clock, so any such divergence is reported within one cycle of reaching a port.

// File: rtl/rbm_pkg.sv
package rbm_pkg;
    localparam int BASE_W = 3;
    localparam int EN_BIT = 7;

    typedef struct packed {
        logic              en;
        logic [BASE_W-1:0] base;
    } blk_ctrl_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HIT  = 2'd1,
        ST_MISS = 2'd2
    } cyc_state_t;
endpackage

// File: rtl/rbm_cfg_regs.sv
module rbm_cfg_regs
    import rbm_pkg::*;
#(
    parameter int NUM_BLOCKS = 8,
    parameter int POP_BLOCKS = 8,
    parameter logic [7:0] ID_CODE = 8'h5A,
    localparam int IDX_W = $clog2(NUM_BLOCKS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        io_sel,
    input  logic                        io_wr,
    input  logic [IDX_W:0]              io_addr,
    input  logic [7:0]                  io_wdata,
    output logic [15:0]                 io_rdata,
    output blk_ctrl_t [NUM_BLOCKS-1:0]  ctrl_o
);
    logic [NUM_BLOCKS-1:0][7:0] raw_q;
    logic [IDX_W-1:0]           word_idx;
    logic                       lo_wr;

    assign word_idx = io_addr[IDX_W:1];
    assign lo_wr    = io_sel && io_wr && !io_addr[0];

    // Only populated slots hold state; the rest stay at zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q <= '0;
        end else begin
            for (int n = 0; n < NUM_BLOCKS; n++) begin
                if (lo_wr && int'(word_idx) == n && n < POP_BLOCKS)
                    raw_q[n] <= io_wdata;
            end
        end
    end

    for (genvar g = 0; g < NUM_BLOCKS; g++) begin : g_fields
        assign ctrl_o[g].en   = raw_q[g][EN_BIT];
        assign ctrl_o[g].base = raw_q[g][BASE_W:1];
    end

    always_comb begin
        io_rdata = '0;
        if (io_sel) begin
            io_rdata[7:0]  = raw_q[word_idx];
            io_rdata[15:8] = (word_idx == '0) ? ID_CODE : 8'h00;
        end
    end

    // R9: a high-byte write leaves every control byte untouched
    p_hi_write_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (io_sel && io_wr && io_addr[0]) |=> $stable(raw_q));

    // R3: unpopulated words read back zero
    p_unpop_reads_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (io_sel && int'(word_idx) >= POP_BLOCKS) |-> (io_rdata[7:0] == 8'h00));
endmodule

// File: rtl/rbm_base_match.sv
module rbm_base_match
    import rbm_pkg::*;
#(
    parameter int NUM_BLOCKS = 8
) (
    input  blk_ctrl_t [NUM_BLOCKS-1:0] ctrl_i,
    input  logic [BASE_W-1:0]          bus_base,
    output logic [NUM_BLOCKS-1:0]      match_vec,
    output logic [NUM_BLOCKS-1:0]      win_onehot,
    output logic                       win_any
);
    for (genvar g = 0; g < NUM_BLOCKS; g++) begin : g_cmp
        assign match_vec[g] = ctrl_i[g].en && (ctrl_i[g].base == bus_base);
    end

    // Fixed priority: lowest index wins
    always_comb begin
        win_onehot = '0;
        win_any    = 1'b0;
        for (int n = 0; n < NUM_BLOCKS; n++) begin
            if (match_vec[n] && !win_any) begin
                win_onehot[n] = 1'b1;
                win_any       = 1'b1;
            end
        end
    end
endmodule

// File: rtl/rbm_cycle_fsm.sv
module rbm_cycle_fsm
    import rbm_pkg::*;
#(
    parameter int NUM_BLOCKS = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_ale,
    input  logic                  bus_mem,
    input  logic                  bus_a0,
    input  logic                  bus_hbe_n,
    input  logic                  bus_rd,
    input  logic                  bus_wr,
    input  logic                  bus_done,
    input  logic [NUM_BLOCKS-1:0] win_onehot,
    input  logic                  win_any,
    output logic [NUM_BLOCKS-1:0] blk_sel,
    output logic [1:0]            lane_we,
    output logic [1:0]            lane_re
);
    cyc_state_t            state_q, state_d;
    logic [NUM_BLOCKS-1:0] sel_q;
    logic [1:0]            lane_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_HIT, ST_MISS: begin
                if (bus_ale) begin
                    if (!bus_mem)     state_d = ST_IDLE;  // latch-io
                    else if (win_any) state_d = ST_HIT;   // latch-hit
                    else              state_d = ST_MISS;  // latch-miss
                end else if (bus_done) begin
                    state_d = ST_IDLE;                     // done
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sel_q   <= '0;
            lane_q  <= '0;
        end else begin
            state_q <= state_d;
            if (bus_ale) begin
                sel_q  <= win_onehot;
                lane_q <= {~bus_hbe_n, ~bus_a0};
            end
        end
    end

    always_comb begin
        blk_sel = '0;
        lane_we = '0;
        lane_re = '0;
        unique case (state_q)
            ST_HIT: begin
                blk_sel = sel_q;
                lane_we = bus_wr ? lane_q : 2'b00;
                lane_re = bus_rd ? lane_q : 2'b00;
            end
            ST_IDLE, ST_MISS: ;
            default: ;
        endcase
    end

    p_sel_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(blk_sel));

    p_io_no_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ale && !bus_mem) |=> (blk_sel == '0));

    p_done_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_done && !bus_ale) |=> (blk_sel == '0 && lane_we == 2'b00));

    p_we_needs_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_we != 2'b00 || lane_re != 2'b00) |-> (blk_sel != '0));
endmodule

// File: rtl/ram_block_mapper.sv
module ram_block_mapper
    import rbm_pkg::*;
#(
    parameter int NUM_BLOCKS = 8,
    parameter int POP_BLOCKS = 8,
    parameter logic [7:0] ID_CODE = 8'h5A,
    localparam int IDX_W = $clog2(NUM_BLOCKS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  io_sel,
    input  logic                  io_wr,
    input  logic [IDX_W:0]        io_addr,
    input  logic [7:0]            io_wdata,
    output logic [15:0]           io_rdata,
    input  logic                  bus_ale,
    input  logic                  bus_mem,
    input  logic [BASE_W-1:0]     bus_base,
    input  logic                  bus_a0,
    input  logic                  bus_hbe_n,
    input  logic                  bus_rd,
    input  logic                  bus_wr,
    input  logic                  bus_done,
    output logic [NUM_BLOCKS-1:0] blk_sel,
    output logic [1:0]            lane_we,
    output logic [1:0]            lane_re
);
    blk_ctrl_t [NUM_BLOCKS-1:0] ctrl;
    logic [NUM_BLOCKS-1:0]      match_vec;
    logic [NUM_BLOCKS-1:0]      win_onehot;
    logic                       win_any;

    rbm_cfg_regs #(
        .NUM_BLOCKS(NUM_BLOCKS),
        .POP_BLOCKS(POP_BLOCKS),
        .ID_CODE   (ID_CODE)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .io_sel  (io_sel),
        .io_wr   (io_wr),
        .io_addr (io_addr),
        .io_wdata(io_wdata),
        .io_rdata(io_rdata),
        .ctrl_o  (ctrl)
    );

    rbm_base_match #(.NUM_BLOCKS(NUM_BLOCKS)) u_match (
        .ctrl_i    (ctrl),
        .bus_base  (bus_base),
        .match_vec (match_vec),
        .win_onehot(win_onehot),
        .win_any   (win_any)
    );

    rbm_cycle_fsm #(.NUM_BLOCKS(NUM_BLOCKS)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_ale   (bus_ale),
        .bus_mem   (bus_mem),
        .bus_a0    (bus_a0),
        .bus_hbe_n (bus_hbe_n),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_done  (bus_done),
        .win_onehot(win_onehot),
        .win_any   (win_any),
        .blk_sel   (blk_sel),
        .lane_we   (lane_we),
        .lane_re   (lane_re)
    );

    // R6: the winner is a matching block with no lower-numbered match
    p_win_lowest_r6: assert property (@(posedge clk) disable iff (!rst_n)
        win_any |-> (((win_onehot & ~match_vec) == '0) &&
                     ((match_vec & (win_onehot - 1'b1)) == '0)));

    // R5: a latched memory cycle with any match produces a select
    p_match_selects_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ale && bus_mem && match_vec != '0) |=> (blk_sel != '0));
endmodule

// File: tb/tb_ram_block_mapper.sv
module tb_ram_block_mapper;
    localparam int NB  = 8;
    localparam int POP = 5;
    localparam logic [7:0] IDC = 8'hA5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic io_sel = 0, io_wr = 0;
    logic [3:0] io_addr = '0;
    logic [7:0] io_wdata = '0;
    logic [15:0] io_rdata;
    logic bus_ale = 0, bus_mem = 0, bus_a0 = 0, bus_hbe_n = 1;
    logic bus_rd = 0, bus_wr = 0, bus_done = 0;
    logic [2:0] bus_base = '0;
    logic [7:0] blk_sel;
    logic [1:0] lane_we, lane_re;

    always #2 clk = ~clk;

    ram_block_mapper #(.NUM_BLOCKS(NB), .POP_BLOCKS(POP), .ID_CODE(IDC)) dut (
        .clk(clk), .rst_n(rst_n), .io_sel(io_sel), .io_wr(io_wr),
        .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .bus_ale(bus_ale), .bus_mem(bus_mem), .bus_base(bus_base),
        .bus_a0(bus_a0), .bus_hbe_n(bus_hbe_n), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_done(bus_done), .blk_sel(blk_sel),
        .lane_we(lane_we), .lane_re(lane_re));

    // Behavioural reference state
    int m_ctrl[NB];
    int m_st;          // 0 idle, 1 hit, 2 miss
    int m_sel;
    int m_lanes;
    int checks = 0;
    int errors = 0;
    bit finished = 0;
    string phase = "R4";

    task automatic model_update();
        if (!rst_n) begin
            foreach (m_ctrl[i]) m_ctrl[i] = 0;
            m_st = 0; m_sel = 0; m_lanes = 0;
        end else begin
            if (bus_ale) begin
                int w;
                w = -1;
                for (int n = 0; n < POP; n++)
                    if (w < 0 && m_ctrl[n][7] && m_ctrl[n][3:1] == int'(bus_base)) w = n;
                m_sel   = (w < 0) ? 0 : (1 << w);
                m_lanes = (bus_hbe_n ? 0 : 2) + (bus_a0 ? 0 : 1);
                if (!bus_mem) m_st = 0;
                else          m_st = (w < 0) ? 2 : 1;
            end else if (bus_done) begin
                m_st = 0;
            end
            if (io_sel && io_wr && !io_addr[0] && int'(io_addr[3:1]) < POP)
                m_ctrl[io_addr[3:1]] = int'(io_wdata);
        end
    endtask

    task automatic cmp(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", phase, what, act, exp);
        end
    endtask

    task automatic compare();
        int e_sel, e_we, e_re, e_rd, w;
        e_sel = (m_st == 1) ? m_sel : 0;
        e_we  = (m_st == 1 && bus_wr) ? m_lanes : 0;
        e_re  = (m_st == 1 && bus_rd) ? m_lanes : 0;
        w = int'(io_addr[3:1]);
        e_rd = 0;
        if (io_sel) e_rd = ((w == 0) ? int'(IDC) << 8 : 0) + ((w < POP) ? m_ctrl[w] : 0);
        cmp("blk_sel", int'(blk_sel), e_sel);
        cmp("lane_we", int'(lane_we), e_we);
        cmp("lane_re", int'(lane_re), e_re);
        cmp("io_rdata", int'(io_rdata), e_rd);
    endtask

    task automatic step();
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare();
    endtask

    task automatic cfg_write(int addr, int data);
        io_sel = 1; io_wr = 1; io_addr = 4'(addr); io_wdata = 8'(data);
        step();
        io_wr = 0;
        step();
        io_sel = 0;
    endtask

    task automatic cfg_read(int addr);
        io_sel = 1; io_addr = 4'(addr);
        step();
        io_sel = 0;
    endtask

    task automatic bus_cycle(bit mem, int base, bit a0, bit hbe_n);
        bus_ale = 1; bus_mem = mem; bus_base = 3'(base); bus_a0 = a0; bus_hbe_n = hbe_n;
        step();
        bus_ale = 0; bus_wr = 1;
        step();
        bus_wr = 0; bus_rd = 1;
        step();
        bus_rd = 0; bus_done = 1;
        step();
        bus_done = 0;
        step();
    endtask

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 20000 && !finished) begin
                finished = 1;
                errors++;
                $display("FAIL watchdog expired");
                $display("  CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        // R4: reset state
        phase = "R4";
        step(); step();
        rst_n = 1;
        step();
        for (int a = 0; a < 16; a += 2) cfg_read(a);
        for (int b = 0; b < 8; b++) bus_cycle(1, b, 0, 0);

        // R1 / R2: program and read back
        phase = "R1";
        cfg_write(0, 8'h86);              // block0 enabled at base 3
        cfg_write(2, 8'h7F);              // block1 all low bits, disabled
        phase = "R2";
        for (int a = 0; a < 16; a += 2) cfg_read(a);

        // R5: mapping sweep
        phase = "R5";
        cfg_write(2, 8'h8A);              // block1 base 5
        cfg_write(4, 8'h80);              // block2 base 0
        cfg_write(8, 8'h8E);              // block4 base 7
        for (int b = 0; b < 8; b++) bus_cycle(1, b, 0, 1);

        // R7: lane patterns
        phase = "R7";
        bus_cycle(1, 3, 0, 1);
        bus_cycle(1, 3, 1, 0);
        bus_cycle(1, 3, 0, 0);
        bus_cycle(1, 3, 1, 1);

        // R6: overlapping bases
        phase = "R6";
        cfg_write(6, 8'h86);              // block3 also base 3
        bus_cycle(1, 3, 0, 0);
        cfg_write(0, 8'h06);              // block0 off, block3 takes over
        bus_cycle(1, 3, 0, 0);

        // R3: unpopulated slots
        phase = "R3";
        cfg_write(12, 8'h82);             // block6 at base 1, not fitted
        cfg_read(12);
        bus_cycle(1, 1, 0, 0);
        cfg_write(10, 8'h84);             // block5 at base 2, not fitted
        bus_cycle(1, 2, 0, 0);

        // R8: I/O cycles, back-to-back latch, done priority
        phase = "R8";
        bus_cycle(0, 5, 0, 0);
        bus_ale = 1; bus_mem = 1; bus_base = 3'd5; bus_a0 = 0; bus_hbe_n = 0;
        step();
        bus_base = 3'd0; bus_done = 1; // ale wins over done
        step();
        bus_ale = 0; bus_done = 0; bus_rd = 1;
        step();
        bus_rd = 0; bus_done = 1;
        step();
        bus_done = 0;
        step();

        // R9: high-byte writes ignored
        phase = "R9";
        cfg_write(1, 8'h00);
        cfg_write(3, 8'h00);
        cfg_read(0);
        cfg_read(2);
        bus_cycle(1, 5, 0, 0);

        // R4: clearing the low bytes disables all mapping
        phase = "R4";
        for (int a = 0; a < 16; a += 2) cfg_write(a, 0);
        for (int b = 0; b < 8; b++) bus_cycle(1, b, 0, 0);

        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule